// File: doc/BRIEF.md
# Configurable Three-Table Logic Cell

This block is a programmable combinational logic cell. It has two 4-input lookup tables, named F and G, and one 3-input lookup table, named H. Two of the H inputs can each be steered either from a table output or from a dedicated cell input. Two output selectors then drive the unregistered outputs `x_out` and `y_out`. When H combines F and G under control of a fifth input, the cell can realise any Boolean function of five variables.

A 44-bit configuration word sets every table bit and every steering bit. The word enters one bit per `cfg_clk` rising edge through a serial chain. Once the last bit is in, the cell is purely combinational. Its outputs follow the data inputs with no clock involved.

The configuration port is a valid-only stream: `cfg_en` qualifies `cfg_sdi`. The chain absorbs a bit on every enabled edge, so there is no back-pressure and no ready signal. Both outputs are held low while a load is incomplete, so a half-written table is never visible.

Top module: `lutcell_top`

## Requirements
- R1: The configuration word is shifted in most significant bit first, one bit per rising `cfg_clk` edge while `cfg_en` is high. The word layout is: bits 43..28 form the F table, where bit 43 is the entry at index 15 and is the first bit sent; bits 27..12 form the G table; bits 11..4 form the H table; bit 3 sets the H `a` source (1 = F output, 0 = `ha_in`); bit 2 sets the H `b` source (1 = G output, 0 = `hb_in`); bit 1 sets the `x_out` source (1 = H, 0 = F); bit 0 sets the `y_out` source (1 = H, 0 = G).
- R2: `cfg_done` rises on the edge that accepts the 44th bit, is low after only 43 bits, and keeps its value on any edge where `cfg_en` is low.
- R3: A shift accepted while `cfg_done` is high starts a fresh load. `cfg_done` falls on that edge and rises again once another full 44-bit word has been accepted.
- R4: While `cfg_done` is low, `x_out` and `y_out` are both 0.
- R5: The F table output is entry `f_in`, with `f_in[0]` as the least significant index bit. When the `x_out` source bit is 0, `x_out` equals this output.
- R6: The G table output is entry `g_in`, with `g_in[0]` as the least significant index bit. When the `y_out` source bit is 0, `y_out` equals this output.
- R7: The H table output is entry {`h1_in`, b, a}, with a as the least significant index bit. The values a and b are taken from the F or G outputs, or from the `ha_in` or `hb_in` pins, as the steering bits in R1 select.
- R8: When an output source bit is 1, the corresponding output equals the H table output.
- R9: Any 5-input function is realised as follows. F holds the half of the function where `h1_in`=0, G holds the half where `h1_in`=1, H holds the selector pattern 8'hCA, and both H steering bits are 1. `x_out` then equals the function at index {`h1_in`, `f_in`}.
- R10: Once configured, outputs change combinationally with the data inputs, with no clock edge between an input change and the output response.
- R11: An asynchronous low on `cfg_rst_n` clears the configuration and `cfg_done` at once, so both outputs read 0.
- R12: While `cfg_en` is low, `cfg_sdi` activity changes neither the configuration nor the cell's function.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Asynchronous active-low clear of the configuration |
| cfg_en | input | 1 | Qualifies `cfg_sdi` on each rising edge |
| cfg_sdi | input | 1 | Serial configuration data, MSB first |
| cfg_done | output | 1 | High once a full configuration word is loaded |
| f_in | input | 4 | F table index |
| g_in | input | 4 | G table index |
| ha_in | input | 1 | Pin source for H input a |
| hb_in | input | 1 | Pin source for H input b |
| h1_in | input | 1 | Fixed H input (most significant H index bit) |
| x_out | output | 1 | F or H result |
| y_out | output | 1 | G or H result |

## Verification
Several input patterns are used, and each separates a different set of faults:

- Plain F and G sweeps with mirrored indices, under the direct output selection, separate index-order faults from table-placement faults.
- Random H tables with table-fed steering, and then with pin-fed steering, show whether each H input comes from the selected source and sits at the right index position.
- Exhaustive sweeps of 32 index values against random 5-input truth tables confirm the full composition.
- A single set first bit shows the shift order.
- Loads with mid-word probes, resets, and idle toggling of `cfg_sdi` separate gating and reload faults from data-path faults.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int unsigned LUT_K    = 4;
  localparam int unsigned H_K      = 3;
  localparam int unsigned LUT_BITS = 1 << LUT_K;
  localparam int unsigned H_BITS   = 1 << H_K;
  localparam int unsigned SEL_BITS = 4;
  localparam int unsigned CFG_W    = 2 * LUT_BITS + H_BITS + SEL_BITS;

  typedef struct packed {
    logic [LUT_BITS-1:0] f_tbl;
    logic [LUT_BITS-1:0] g_tbl;
    logic [H_BITS-1:0]   h_tbl;
    logic                ha_from_f;
    logic                hb_from_g;
    logic                x_from_h;
    logic                y_from_h;
  } cell_cfg_t;
endpackage

// File: rtl/lutcell_cfg_chain.sv
module lutcell_cfg_chain #(
  parameter int unsigned W = 44
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         done
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt;

  // Shift register doubles as the live configuration store.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (en) begin
      word <= {word[W-2:0], sdi};
      if (done) begin
        cnt  <= CNT_W'(1);
        done <= 1'b0;
      end else begin
        cnt  <= cnt + CNT_W'(1);
        done <= (cnt == CNT_W'(W - 1));
      end
    end
  end
endmodule

// File: rtl/lutcell_table.sv
module lutcell_table #(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic [K-1:0]      idx,
  output logic              o
);
  assign o = tbl[idx];
endmodule

// File: rtl/lutcell_h_steer.sv
module lutcell_h_steer (
  input  logic       f_o,
  input  logic       g_o,
  input  logic       ha_in,
  input  logic       hb_in,
  input  logic       h1_in,
  input  logic       ha_from_f,
  input  logic       hb_from_g,
  output logic [2:0] h_idx
);
  logic a_v, b_v;

  always_comb begin
    a_v   = ha_from_f ? f_o : ha_in;
    b_v   = hb_from_g ? g_o : hb_in;
    h_idx = {h1_in, b_v, a_v};
  end
endmodule

// File: rtl/lutcell_out_sel.sv
module lutcell_out_sel (
  input  logic live,
  input  logic f_o,
  input  logic g_o,
  input  logic h_o,
  input  logic x_from_h,
  input  logic y_from_h,
  output logic x_out,
  output logic y_out
);
  always_comb begin
    x_out = live & (x_from_h ? h_o : f_o);
    y_out = live & (y_from_h ? h_o : g_o);
  end
endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
(
  input  logic             cfg_clk,
  input  logic             cfg_rst_n,
  input  logic             cfg_en,
  input  logic             cfg_sdi,
  output logic             cfg_done,
  input  logic [LUT_K-1:0] f_in,
  input  logic [LUT_K-1:0] g_in,
  input  logic             ha_in,
  input  logic             hb_in,
  input  logic             h1_in,
  output logic             x_out,
  output logic             y_out
);
  localparam int unsigned N_LUT = 2;

  logic [CFG_W-1:0] cfg_word;
  cell_cfg_t        cfg;

  logic [N_LUT-1:0][LUT_BITS-1:0] tbls;
  logic [N_LUT-1:0][LUT_K-1:0]    idxs;
  logic [N_LUT-1:0]               lut_o;
  logic [H_K-1:0]                 h_idx;
  logic                           h_o;

  lutcell_cfg_chain #(.W(CFG_W)) u_chain (
    .clk  (cfg_clk),
    .rst_n(cfg_rst_n),
    .en   (cfg_en),
    .sdi  (cfg_sdi),
    .word (cfg_word),
    .done (cfg_done)
  );

  assign cfg     = cell_cfg_t'(cfg_word);
  assign tbls[0] = cfg.f_tbl;
  assign tbls[1] = cfg.g_tbl;
  assign idxs[0] = f_in;
  assign idxs[1] = g_in;

  for (genvar gi = 0; gi < N_LUT; gi++) begin : g_lut4
    lutcell_table #(.K(LUT_K)) u_tbl (
      .tbl(tbls[gi]),
      .idx(idxs[gi]),
      .o  (lut_o[gi])
    );
  end

  lutcell_h_steer u_steer (
    .f_o      (lut_o[0]),
    .g_o      (lut_o[1]),
    .ha_in    (ha_in),
    .hb_in    (hb_in),
    .h1_in    (h1_in),
    .ha_from_f(cfg.ha_from_f),
    .hb_from_g(cfg.hb_from_g),
    .h_idx    (h_idx)
  );

  lutcell_table #(.K(H_K)) u_htbl (
    .tbl(cfg.h_tbl),
    .idx(h_idx),
    .o  (h_o)
  );

  lutcell_out_sel u_out (
    .live    (cfg_done),
    .f_o     (lut_o[0]),
    .g_o     (lut_o[1]),
    .h_o     (h_o),
    .x_from_h(cfg.x_from_h),
    .y_from_h(cfg.y_from_h),
    .x_out   (x_out),
    .y_out   (y_out)
  );
endmodule

// File: rtl/lutcell_chk.sv
module lutcell_chk
  import lutcell_pkg::*;
(
  input logic             cfg_clk,
  input logic             cfg_rst_n,
  input logic             cfg_en,
  input logic             cfg_done,
  input logic [LUT_K-1:0] f_in,
  input logic [LUT_K-1:0] g_in,
  input logic             ha_in,
  input logic             hb_in,
  input logic             h1_in,
  input logic             x_out,
  input logic             y_out
);
  // R2: completion only on an accepted bit
  a_r2_done_needs_shift: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $rose(cfg_done) |-> $past(cfg_en));

  // R2: idle edges keep the flag
  a_r2_done_hold: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_en |=> $stable(cfg_done));

  // R3: the flag only drops when a new load begins
  a_r3_restart: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $fell(cfg_done) |-> $past(cfg_en));

  // R4: outputs dark while incomplete
  a_r4_dark: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_done |-> (!x_out && !y_out));

  // R12: no shift, same inputs -> same outputs
  a_r12_frozen: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    (cfg_done && $past(cfg_done) && !$past(cfg_en) && $stable(f_in) && $stable(g_in)
     && $stable(ha_in) && $stable(hb_in) && $stable(h1_in))
    |-> ($stable(x_out) && $stable(y_out)));
endmodule

bind lutcell_top lutcell_chk u_chk (.*);

// File: tb/sim_lutcell_top.sv
module sim_lutcell_top;
  import lutcell_pkg::*;
  localparam int W = CFG_W;

  logic cfg_clk = 1'b0, cfg_rst_n = 1'b0, cfg_en = 1'b0, cfg_sdi = 1'b0;
  logic [3:0] f_in = '0, g_in = '0;
  logic ha_in = 1'b0, hb_in = 1'b0, h1_in = 1'b0;
  logic cfg_done, x_out, y_out;

  lutcell_top u0 (.*);

  always #4 cfg_clk = ~cfg_clk;  // 125 MHz

  typedef struct { logic ex; logic ey; string tag; } exp_t;
  exp_t sb[$];
  event ev_chk;
  int checks = 0, fails = 0;
  logic [W-1:0] cur_cfg = '0;
  bit loaded = 0;

  function automatic logic [W-1:0] mk(logic [15:0] ft, logic [15:0] gt, logic [7:0] ht,
                                      logic a_f, logic b_g, logic x_h, logic y_h);
    return {ft, gt, ht, a_f, b_g, x_h, y_h};
  endfunction

  // Reference from R1, R4-R8
  task automatic model(input logic [3:0] f, input logic [3:0] g, input logic a, input logic b,
                       input logic h1, output logic ex, output logic ey);
    logic fo, go, av, bv, ho;
    fo = cur_cfg[28 + f];
    go = cur_cfg[12 + g];
    av = cur_cfg[3] ? fo : a;
    bv = cur_cfg[2] ? go : b;
    ho = cur_cfg[4 + {h1, bv, av}];
    ex = loaded ? (cur_cfg[1] ? ho : fo) : 1'b0;
    ey = loaded ? (cur_cfg[0] ? ho : go) : 1'b0;
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive_exp(logic [3:0] f, logic [3:0] g, logic a, logic b, logic h1,
                           logic ex, logic ey, string tag);
    exp_t e;
    f_in = f; g_in = g; ha_in = a; hb_in = b; h1_in = h1;
    e.ex = ex; e.ey = ey; e.tag = tag;
    sb.push_back(e);
    ->ev_chk;
    #3;
  endtask

  task automatic drive(logic [3:0] f, logic [3:0] g, logic a, logic b, logic h1, string tag);
    logic ex, ey;
    model(f, g, a, b, h1, ex, ey);
    drive_exp(f, g, a, b, h1, ex, ey, tag);
  endtask

  // Monitor: pops the scoreboard after the combinational settle
  initial forever begin
    @(ev_chk);
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (x_out !== e.ex || y_out !== e.ey) begin
        fails++;
        $display("FAIL %s x,y actual=%b,%b expected=%b,%b", e.tag, x_out, y_out, e.ex, e.ey);
      end
    end
  end

  task automatic load(logic [W-1:0] c, bit probe);
    loaded = 0;
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge cfg_clk);
      if (i == 0) check("R2 done after 43 bits", cfg_done, 1'b0);
      if (probe && i == W / 2) begin
        check("R3 done low mid reload", cfg_done, 1'b0);
        drive(4'hF, 4'hF, 1'b1, 1'b1, 1'b1, "R4 dark mid reload");
      end
      cfg_en = 1'b1; cfg_sdi = c[i];
    end
    @(negedge cfg_clk);
    cfg_en = 1'b0;
    check("R2 done after 44 bits", cfg_done, 1'b1);
    cur_cfg = c;
    loaded = 1;
  endtask

  task automatic rand_sweep(int n, string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      drive(r[3:0], r[7:4], 1'($urandom), 1'($urandom), 1'($urandom), tag);
    end
  endtask

  task automatic finish_run();
    #10;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #10;
    // R11 reset state, R4 dark outputs
    check("R11 reset done", cfg_done, 1'b0);
    drive(4'hF, 4'hF, 1'b1, 1'b1, 1'b1, "R4 dark after reset");
    @(negedge cfg_clk);
    cfg_rst_n = 1'b1;

    // R1: only the first bit sent set -> F entry 15
    load(mk(16'h8000, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0), 0);
    drive_exp(4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R1 msb first");
    drive_exp(4'hE, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 msb first");

    // R5, R6: plain tables, mirrored indices
    load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0), 0);
    for (int i = 0; i < 16; i++) drive(4'(i), 4'(15 - i), 1'b0, 1'b0, 1'b0, "R5 R6 direct");

    // R7, R8: H fed from tables
    load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1'b1, 1'b1, 1'b1, 1'b1), 0);
    rand_sweep(32, "R7 R8 table fed");
    // R7: H fed from pins, mixed selects
    load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b1, 1'b0), 0);
    for (int i = 0; i < 8; i++) drive(4'h5, 4'hA, i[0], i[1], i[2], "R7 pin fed");
    load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1'b1, 1'b0, 1'b0, 1'b1), 0);
    rand_sweep(32, "R7 R8 mixed");

    // R9: any 5-input function
    for (int t = 0; t < 4; t++) begin
      logic [31:0] tt;
      tt = $urandom;
      load(mk(tt[15:0], tt[31:16], 8'hCA, 1'b1, 1'b1, 1'b1, 1'b0), 0);
      for (int v = 0; v < 32; v++)
        drive_exp(4'(v), 4'(v), 1'($urandom), 1'($urandom), v[4], tt[v], tt[16 + v[3:0]],
                  "R9 five input");
    end

    // R10: change right after an edge, checked before the next
    @(posedge cfg_clk);
    #1 drive(4'h3, 4'hC, 1'b1, 1'b0, 1'b1, "R10 comb");
    drive(4'hC, 4'h3, 1'b0, 1'b1, 1'b0, "R10 comb");

    // R12: idle toggling of serial data
    for (int k = 0; k < 12; k++) begin
      @(negedge cfg_clk);
      cfg_sdi = ~cfg_sdi;
    end
    @(negedge cfg_clk);
    check("R12 done kept", cfg_done, 1'b1);
    rand_sweep(16, "R12 unchanged");

    // R3: reload with mid-word probe
    load(mk(16'($urandom), 16'($urandom), 8'($urandom), 1'b1, 1'b1, 1'b0, 1'b1), 1);
    rand_sweep(16, "R3 new word");

    // R11: asynchronous clear mid-cycle
    @(posedge cfg_clk);
    #2 cfg_rst_n = 1'b0;
    #1 check("R11 async done", cfg_done, 1'b0);
    loaded = 0;
    drive(4'hF, 4'hF, 1'b1, 1'b1, 1'b1, "R11 outputs cleared");
    finish_run();
  end
endmodule